// File: doc/BRIEF.md
# SD/MMC bus clock generator

This block makes the clock that drives a memory card bus. It runs on a core clock at twice the fixed 19.5 MHz reference rate. The card clock toggles once every 2^div core cycles, so its frequency is the reference divided by 2^div. The divider code can be 0 to 6, and code 7 is reserved.

Software controls the clock through a control write. A start loads the divider code and sets the clock running. A stop is only a request: the clock halts at the next phase boundary and its output is left low. Once the clock has actually stopped, the running bit in the status word clears and the clock-off interrupt source is raised. That source can be masked.

For each command, the block can first send an initialization burst of 80 card clock rising edges, after which it signals that the command may begin. Without the burst, the command may begin one cycle after it is issued.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the card clock is low, the status word and the raw interrupt vector are zero, irq_out is low, init_busy is low and cmd_start is low. Every interrupt mask bit resets to 1.
- R2: While running with a captured divider code d, each high phase and each low phase of card_clk lasts exactly 2^d core cycles. The first phase after a start is low.
- R3: The divider code is captured only when a start is accepted. Changing div_code while the clock runs leaves the phase length unchanged.
- R4: A start write (ctl_code 2'b10) while the clock is running, or while a stop is pending, has no effect on the phase length or on the running state.
- R5: A start write with div_code 7 leaves the clock stopped, with card_clk low and status bit 8 low.
- R6: A stop write (ctl_code 2'b01) takes effect at the next phase boundary, at most 2^d cycles after it is sampled. card_clk then stays low, and no phase is shortened. Status bit 8 is 1 exactly while the clock runs. ctl_code values 2'b00 and 2'b11 do nothing.
- R7: Raw interrupt bit 4 sets in the cycle the stop completes and clears when the next start is accepted. irq_out is the OR of the raw bits ANDed with the inverted mask. A mask write replaces the whole mask.
- R8: cmd_go with cmd_init raises init_busy. cmd_start pulses in the same cycle as the 80th rising card_clk edge counted after cmd_go is sampled, and init_busy falls at that point.
- R9: cmd_go without cmd_init gives a one-cycle cmd_start pulse in the cycle after cmd_go is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the reference rate |
| rst_n | input | 1 | Active-low synchronous reset |
| div_code | input | 3 | Divider code, captured at start |
| ctl_wr | input | 1 | Control write strobe |
| ctl_code | input | 2 | Control code: 2'b10 start, 2'b01 stop |
| mask_wr | input | 1 | Interrupt mask write strobe |
| mask_wdata | input | 12 | New interrupt mask value |
| cmd_go | input | 1 | Command issue pulse |
| cmd_init | input | 1 | Request the init burst with this command |
| card_clk | output | 1 | Card bus clock |
| stat_word | output | 16 | Status word, bit 8 = clock running |
| irq_raw | output | 12 | Raw interrupt sources, bit 4 = clock off |
| irq_out | output | 1 | Masked interrupt request |
| init_busy | output | 1 | Init burst in progress |
| cmd_start | output | 1 | Command may begin (one-cycle pulse) |

## Verification
A wrong phase counter or a divider code captured at the wrong time shows up as a card_clk phase of the wrong length. That error is visible at the first edge that follows, within 2^d cycles. A stale stop-pending flag would cut off a phase, or leave status bit 8 set past the stop bound. A burst counter that is off by one moves cmd_start by a whole card clock period against the bench's count of rising edges. A wrongly sticky or wrongly cleared clock-off bit appears at irq_raw and irq_out in the cycle after the stop or start.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int DIV_W      = 3;
  localparam int DIV_MAX    = 6;
  localparam logic [DIV_W-1:0] DIV_HOLD = 3'd7;
  localparam int CNT_W      = DIV_MAX;
  localparam int INIT_CLKS  = 80;
  localparam int IRQ_W      = 12;
  localparam int IRQ_OFF_BIT = 4;
  localparam int STAT_W     = 16;
  localparam int STAT_RUN_BIT = 8;

  typedef enum logic [1:0] {
    CTL_NOP   = 2'b00,
    CTL_STOP  = 2'b01,
    CTL_START = 2'b10,
    CTL_RSVD  = 2'b11
  } ctl_code_e;
endpackage

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic [DIV_W-1:0] div_code,
  output logic             card_clk,
  output logic             running,
  output logic             rise_evt,
  output logic             stop_done,
  output logic             start_acc
);
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             stop_pend;
  logic             edge_pt;

  always_comb begin
    lim       = CNT_W'((32'd1 << div_q) - 32'd1);
    edge_pt   = running && (cnt == lim);
    start_acc = start_req && !running && (div_code != DIV_HOLD);
    stop_done = edge_pt && stop_pend;
    rise_evt  = edge_pt && !stop_pend && !card_clk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      div_q     <= '0;
      cnt       <= '0;
      card_clk  <= 1'b0;
      stop_pend <= 1'b0;
    end else if (start_acc) begin
      running   <= 1'b1;
      div_q     <= div_code;
      cnt       <= '0;
      card_clk  <= 1'b0;
      stop_pend <= 1'b0;
    end else if (running) begin
      if (stop_req) stop_pend <= 1'b1;
      if (edge_pt) begin
        cnt <= '0;
        if (stop_pend) begin
          running   <= 1'b0;
          card_clk  <= 1'b0;
          stop_pend <= 1'b0;
        end else begin
          card_clk <= ~card_clk;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_DIV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> $stable(div_q)); // R3
  AST_HOLD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !running && div_code == DIV_HOLD) |=> !running); // R5
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !card_clk); // R6
endmodule

// File: rtl/sdclk_init_burst.sv
module sdclk_init_burst #(
  parameter int INIT_CLKS = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_go,
  input  logic cmd_init,
  input  logic rise_evt,
  output logic busy,
  output logic cmd_start
);
  localparam int BC_W = $clog2(INIT_CLKS + 1);

  logic [BC_W-1:0] bcnt;

  assign busy = (bcnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt      <= '0;
      cmd_start <= 1'b0;
    end else begin
      cmd_start <= 1'b0;
      if (cmd_go && !busy) begin
        if (cmd_init) bcnt <= BC_W'(INIT_CLKS);
        else          cmd_start <= 1'b1;
      end else if (busy && rise_evt) begin
        bcnt <= bcnt - 1'b1;
        if (bcnt == BC_W'(1)) cmd_start <= 1'b1;
      end
    end
  end

  AST_BURST_ENDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cmd_start); // R8
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start); // R9
endmodule

// File: rtl/sdclk_irq.sv
module sdclk_irq #(
  parameter int IRQ_W   = 12,
  parameter int OFF_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_done,
  input  logic             start_acc,
  input  logic             mask_wr,
  input  logic [IRQ_W-1:0] mask_wdata,
  output logic [IRQ_W-1:0] irq_raw,
  output logic             irq_out
);
  logic [IRQ_W-1:0] mask_q;
  logic             off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      off_q  <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      if (stop_done)      off_q <= 1'b1;
      else if (start_acc) off_q <= 1'b0;
    end
  end

  for (genvar b = 0; b < IRQ_W; b++) begin : g_raw
    if (b == OFF_BIT) begin : g_off
      assign irq_raw[b] = off_q;
    end else begin : g_zero
      assign irq_raw[b] = 1'b0;
    end
  end

  assign irq_out = |(irq_raw & ~mask_q);

  AST_OFF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> irq_raw[OFF_BIT]); // R7
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> !irq_raw[OFF_BIT]); // R7
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int INIT_CNT = INIT_CLKS,
  parameter int IW       = IRQ_W,
  parameter int SW       = STAT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_code,
  input  logic             ctl_wr,
  input  logic [1:0]       ctl_code,
  input  logic             mask_wr,
  input  logic [IW-1:0]    mask_wdata,
  input  logic             cmd_go,
  input  logic             cmd_init,
  output logic             card_clk,
  output logic [SW-1:0]    stat_word,
  output logic [IW-1:0]    irq_raw,
  output logic             irq_out,
  output logic             init_busy,
  output logic             cmd_start
);
  logic start_req, stop_req, running, rise_evt, stop_done, start_acc;

  assign start_req = ctl_wr && (ctl_code == CTL_START);
  assign stop_req  = ctl_wr && (ctl_code == CTL_STOP);

  sdclk_divider u_div (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .div_code(div_code), .card_clk(card_clk), .running(running),
    .rise_evt(rise_evt), .stop_done(stop_done), .start_acc(start_acc)
  );

  sdclk_init_burst #(.INIT_CLKS(INIT_CNT)) u_init (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_init(cmd_init),
    .rise_evt(rise_evt), .busy(init_busy), .cmd_start(cmd_start)
  );

  sdclk_irq #(.IRQ_W(IW), .OFF_BIT(IRQ_OFF_BIT)) u_irq (
    .clk(clk), .rst_n(rst_n), .stop_done(stop_done), .start_acc(start_acc),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .irq_raw(irq_raw),
    .irq_out(irq_out)
  );

  for (genvar b = 0; b < SW; b++) begin : g_stat
    if (b == STAT_RUN_BIT) begin : g_run
      assign stat_word[b] = running;
    end else begin : g_zero
      assign stat_word[b] = 1'b0;
    end
  end
endmodule

// File: tb/sdclk_gen_tb_top.sv
module sdclk_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  div_code = '0;
  logic        ctl_wr = 1'b0;
  logic [1:0]  ctl_code = 2'b00;
  logic        mask_wr = 1'b0;
  logic [11:0] mask_wdata = '0;
  logic        cmd_go = 1'b0;
  logic        cmd_init = 1'b0;
  logic        card_clk;
  logic [15:0] stat_word;
  logic [11:0] irq_raw;
  logic        irq_out;
  logic        init_busy;
  logic        cmd_start;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int exp_q[$];
  int cur_exp = 0;
  int hi_run = 0, lo_run = 0, rise_cnt = 0;
  logic prev_on = 1'b0, prev_ck = 1'b0;

  always #5 clk = ~clk;

  sdclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .div_code(div_code), .ctl_wr(ctl_wr),
    .ctl_code(ctl_code), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .cmd_go(cmd_go), .cmd_init(cmd_init), .card_clk(card_clk),
    .stat_word(stat_word), .irq_raw(irq_raw), .irq_out(irq_out),
    .init_busy(init_busy), .cmd_start(cmd_start)
  );

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops the expected phase length at each start, checks every phase
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_on = 1'b0; prev_ck = 1'b0; hi_run = 0; lo_run = 0;
    end else begin
      if (stat_word[8] && !prev_on) begin
        if (exp_q.size() == 0) chk("R4/R5 unexpected start", 1, 0);
        else cur_exp = exp_q.pop_front();
      end
      if (prev_ck && !card_clk) begin
        chk("R2/R6 high phase length", hi_run, cur_exp);
        hi_run = 0;
      end
      if (!prev_ck && card_clk) begin
        chk("R2 low phase length", lo_run, cur_exp);
        lo_run = 0;
        rise_cnt++;
      end
      if (card_clk) hi_run++;
      else if (stat_word[8]) lo_run++;
      else lo_run = 0;
      prev_on = stat_word[8];
      prev_ck = card_clk;
    end
  end

  task automatic ctl(logic [1:0] code, logic [2:0] d, bit push);
    @(posedge clk); #2;
    div_code = d; ctl_wr = 1'b1; ctl_code = code;
    if (push) exp_q.push_back(1 << d);
    @(posedge clk); #2;
    ctl_wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic stop_and_measure(int d);
    int k = 0;
    ctl(2'b01, div_code, 0);
    do begin @(negedge clk); k++; end while (stat_word[8] && k < 200);
    n_vec++;
    if (k < 2 || k > (1 << d) + 1) begin
      n_bad++;
      $display("FAIL R6 stop latency: actual %0d expected 2..%0d", k, (1 << d) + 1);
    end
    chk("R6 clock low after stop", card_clk, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int k;
    idle(3); #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 card_clk", card_clk, 0);
    chk("R1 stat_word", int'(stat_word), 0);
    chk("R1 irq_raw", int'(irq_raw), 0);
    chk("R1 irq_out", irq_out, 0);
    chk("R1 init_busy", init_busy, 0);
    chk("R1 cmd_start", cmd_start, 0);

    // reserved ctl codes do nothing
    ctl(2'b11, 3'd0, 0);
    ctl(2'b00, 3'd0, 0);
    @(negedge clk);
    chk("R6 reserved codes keep stopped", stat_word[8], 0);

    // R2 at d=0 then stop; R7 masked by reset mask
    ctl(2'b10, 3'd0, 1);
    idle(20);
    @(negedge clk);
    chk("R6 status bit 8 while running", stat_word[8], 1);
    stop_and_measure(0);
    chk("R7 raw bit 4 after stop", irq_raw[4], 1);
    chk("R7 reset mask hides irq", irq_out, 0);

    @(posedge clk); #2 mask_wr = 1'b1; mask_wdata = 12'hFEF;
    @(posedge clk); #2 mask_wr = 1'b0;
    @(negedge clk);
    chk("R7 unmasked irq_out", irq_out, 1);

    // R2 at d=2, R7 clear on start
    ctl(2'b10, 3'd2, 1);
    @(negedge clk);
    chk("R7 raw bit 4 cleared by start", irq_raw[4], 0);
    chk("R7 irq_out cleared by start", irq_out, 0);
    idle(40);
    // R3: change divider without a start
    @(posedge clk); #2 div_code = 3'd0;
    idle(40);
    // R4: start while running with another divider
    ctl(2'b10, 3'd5, 0);
    idle(40);
    stop_and_measure(2);

    // R2 at d=3
    ctl(2'b10, 3'd3, 1);
    idle(70);
    stop_and_measure(3);

    // R5: reserved divider code
    ctl(2'b10, 3'd7, 0);
    idle(30);
    @(negedge clk);
    chk("R5 stays stopped", stat_word[8], 0);
    chk("R5 clock low", card_clk, 0);

    // R8: init burst at d=1
    ctl(2'b10, 3'd1, 1);
    @(posedge card_clk); #2;
    cmd_go = 1'b1; cmd_init = 1'b1;
    @(posedge clk); #2 cmd_go = 1'b0; cmd_init = 1'b0;
    @(negedge clk); #1 rise_cnt = 0;
    chk("R8 init_busy during burst", init_busy, 1);
    k = 0;
    do begin @(negedge clk); #1; k++; end while (!cmd_start && k < 2000);
    chk("R8 rising edges before cmd_start", rise_cnt, 80);
    chk("R8 init_busy after burst", init_busy, 0);

    // R9: no burst
    @(posedge clk); #2 cmd_go = 1'b1;
    @(negedge clk);
    chk("R9 not yet", cmd_start, 0);
    @(posedge clk); #2 cmd_go = 1'b0;
    @(negedge clk);
    chk("R9 cmd_start pulse", cmd_start, 1);
    @(negedge clk);
    chk("R9 pulse one cycle", cmd_start, 0);
    stop_and_measure(1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule